// File: doc/BRIEF.md
# Single-Bit Boolean Processor

This block carries out the bit-level operations of a small controller core. It keeps a one-bit accumulator, the carry, and works on a 256-entry bit address space. The lower half of that space maps onto bit-addressable bytes of internal RAM. The upper half maps onto the individual bits of special-function registers whose byte address is a multiple of eight. One request names a bit and an operation.

For an operation that touches a bit, the block reads the byte that holds the bit. It computes the new bit value, the new carry, and a branch decision. When the operation changes the bit, it writes the byte back with the other seven bits unchanged. The instruction sequencer uses the branch decision for the three conditional jump operations. The sequencer computes the jump target itself. The byte storage sits outside the block and answers reads in the same cycle (combinational read data).

The controller is a four-state machine:
- `ST_IDLE` waits for `op_valid`. A carry-only operation moves to `ST_DONE` and updates carry at that edge. Any other operation moves to `ST_READ`.
- `ST_READ` drives the byte address with `mem_rd` and captures the returned byte. It always moves to `ST_EXEC`.
- `ST_EXEC` updates carry and the branch decision. It pulses `mem_wr` with the merged byte when the operation modifies the bit, then moves to `ST_DONE`.
- `ST_DONE` raises `done` (and `jump_taken` if the branch is taken) for one cycle and returns to `ST_IDLE`.

Top module: `bitproc_unit`

## Requirements
- R1: After reset, and after a reset applied in the middle of an operation, carry is 0 and `done`, `jump_taken`, `busy`, `mem_rd` and `mem_wr` are all 0.
- R2: Bit address 0x00–0x7F selects byte 0x20 + (addr >> 3), and bit position addr[2:0]. For example, 0x00 is byte 0x20 bit 0, and 0x7F is byte 0x2F bit 7.
- R3: Bit address 0x80–0xFF selects byte (addr & 0xF8), and bit position addr[2:0]. For example, 0x80 is byte 0x80 bit 0, and 0xFF is byte 0xF8 bit 7.
- R4: The following operations each perform exactly one write, and the written byte differs from the byte read in the target bit only:
  - op 0 sets the bit.
  - op 1 clears the bit.
  - op 2 complements the bit.
- R5: Op 6 copies the bit into carry and does not write. Op 7 writes carry into the bit.
- R6: The following operations write the result to carry and perform no write:
  - op 8 computes carry AND bit.
  - op 9 computes carry AND NOT bit.
  - op 10 computes carry OR bit.
  - op 11 computes carry OR NOT bit.
- R7: Op 3 (jump if set) and op 4 (jump if clear) raise `jump_taken` in the `done` cycle when the condition holds. Neither writes.
- R8: Op 5 (jump if set then clear) tests the bit and, in the same read-modify-write, clears it and signals a jump when the bit was 1. When the bit was 0, it performs no write and no jump.
- R9: The following operations make no memory access and raise `done` in the cycle after acceptance:
  - op 12 sets carry.
  - op 13 clears carry.
  - op 14 complements carry.
  - op 15 changes nothing.
- R10: A bit operation reads in the cycle after acceptance and, if it writes, writes the same byte address in the next cycle. It raises `done` three cycles after acceptance, and carry changes only at the edge that enters `done`.
- R11: `done` is a single-cycle pulse, and `jump_taken` is only ever high together with `done`.
- R12: While `busy` is high, `op_valid` and `op_code` are ignored. A carry operation presented then has no effect on carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Request strobe, sampled in the idle state |
| op_code | input | 4 | Operation code (see R4–R9) |
| bit_addr | input | 8 | Bit address in the 256-entry bit space |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| jump_taken | output | 1 | Branch condition met, valid with done |
| carry | output | 1 | Carry accumulator |
| mem_rd | output | 1 | Byte read strobe |
| mem_wr | output | 1 | Byte write strobe |
| mem_addr | output | 8 | Byte address for read and write |
| mem_wdata | output | 8 | Merged byte to write |
| mem_rdata | input | 8 | Byte returned for mem_addr, same cycle |

## Verification
The vector walk starts with carry at 0 and with bytes holding mixed patterns such as 0xA5 and 0x3C. Each logical operation is then applied to bits that are 1 and to bits that are 0, which separates the true and complemented operand forms. Each jump test is run once against a set bit and once against a clear bit. The jump-then-clear operation is repeated on the same bit, which shows that the write happens only while the bit is set. Directed cases cover:
- the edges of both address halves, with neighbouring bytes checked for disturbance;
- a carry request presented while the block is busy;
- a reset taken partway through an operation.

// File: rtl/bitproc_pkg.sv
package bitproc_pkg;

    typedef enum logic [3:0] {
        BOP_SET     = 4'd0,
        BOP_CLR     = 4'd1,
        BOP_TGL     = 4'd2,
        BOP_JSET    = 4'd3,
        BOP_JCLR    = 4'd4,
        BOP_JSETCLR = 4'd5,
        BOP_LDC     = 4'd6,
        BOP_STC     = 4'd7,
        BOP_ANDC    = 4'd8,
        BOP_ANDNC   = 4'd9,
        BOP_ORC     = 4'd10,
        BOP_ORNC    = 4'd11,
        BOP_CSET    = 4'd12,
        BOP_CCLR    = 4'd13,
        BOP_CTGL    = 4'd14,
        BOP_NOP     = 4'd15
    } bp_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_EXEC,
        ST_DONE
    } bp_state_e;

    // Carry-only operations occupy the top quarter of the code space.
    function automatic logic is_carry_only(input bp_op_e op);
        return (op[3:2] == 2'b11);
    endfunction

endpackage

// File: rtl/bitproc_addr_map.sv
module bitproc_addr_map #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] RAM_BASE = 8'h20
) (
    input  logic [ADDR_W-1:0]         bit_addr,
    output logic [ADDR_W-1:0]         byte_addr,
    output logic [$clog2(DATA_W)-1:0] bit_pos
);
    localparam int POS_W = $clog2(DATA_W);

    always_comb begin
        if (!bit_addr[ADDR_W-1]) begin
            // Lower half: RAM bytes counted from the base.
            byte_addr = RAM_BASE + ADDR_W'(bit_addr[ADDR_W-2:POS_W]);
        end else begin
            // Upper half: register bytes aligned to multiples of eight.
            byte_addr = {bit_addr[ADDR_W-1:POS_W], POS_W'(0)};
        end
        bit_pos = bit_addr[POS_W-1:0];
    end
endmodule

// File: rtl/bitproc_bit_alu.sv
module bitproc_bit_alu
    import bitproc_pkg::*;
(
    input  bp_op_e op,
    input  logic   cur_bit,
    input  logic   carry_in,
    output logic   new_bit,
    output logic   new_carry,
    output logic   wr_en,
    output logic   jump
);
    always_comb begin
        new_bit   = cur_bit;
        new_carry = carry_in;
        wr_en     = 1'b0;
        jump      = 1'b0;
        unique case (op)
            BOP_SET:     begin new_bit = 1'b1;     wr_en = 1'b1; end
            BOP_CLR:     begin new_bit = 1'b0;     wr_en = 1'b1; end
            BOP_TGL:     begin new_bit = ~cur_bit; wr_en = 1'b1; end
            BOP_JSET:    jump = cur_bit;
            BOP_JCLR:    jump = ~cur_bit;
            BOP_JSETCLR: begin
                jump    = cur_bit;
                new_bit = 1'b0;
                wr_en   = cur_bit;
            end
            BOP_LDC:     new_carry = cur_bit;
            BOP_STC:     begin new_bit = carry_in; wr_en = 1'b1; end
            BOP_ANDC:    new_carry = carry_in & cur_bit;
            BOP_ANDNC:   new_carry = carry_in & ~cur_bit;
            BOP_ORC:     new_carry = carry_in | cur_bit;
            BOP_ORNC:    new_carry = carry_in | ~cur_bit;
            BOP_CSET:    new_carry = 1'b1;
            BOP_CCLR:    new_carry = 1'b0;
            BOP_CTGL:    new_carry = ~carry_in;
            BOP_NOP:     new_carry = carry_in;
        endcase
    end
endmodule

// File: rtl/bitproc_byte_merge.sv
module bitproc_byte_merge #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0]         byte_in,
    input  logic [$clog2(DATA_W)-1:0] pos,
    input  logic                      new_bit,
    output logic [DATA_W-1:0]         byte_out
);
    localparam int POS_W = $clog2(DATA_W);

    for (genvar i = 0; i < DATA_W; i++) begin : g_lane
        assign byte_out[i] = (pos == POS_W'(i)) ? new_bit : byte_in[i];
    end
endmodule

// File: rtl/bitproc_unit.sv
module bitproc_unit
    import bitproc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] RAM_BASE = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic [ADDR_W-1:0] bit_addr,
    output logic              busy,
    output logic              done,
    output logic              jump_taken,
    output logic              carry,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int POS_W = $clog2(DATA_W);

    bp_state_e         state_q, state_d;
    bp_op_e            op_q, alu_op;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] byte_q;
    logic              carry_q;
    logic              jump_q;

    logic [ADDR_W-1:0] byte_addr;
    logic [POS_W-1:0]  bit_pos;
    logic              cur_bit, alu_bit, alu_carry, alu_wr, alu_jump;
    logic [DATA_W-1:0] merged;
    logic              accept;

    assign accept  = (state_q == ST_IDLE) && op_valid;
    assign alu_op  = (state_q == ST_IDLE) ? bp_op_e'(op_code) : op_q;
    assign cur_bit = byte_q[bit_pos];

    bitproc_addr_map #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .RAM_BASE (RAM_BASE)
    ) u_map (
        .bit_addr  (addr_q),
        .byte_addr (byte_addr),
        .bit_pos   (bit_pos)
    );

    bitproc_bit_alu u_alu (
        .op        (alu_op),
        .cur_bit   (cur_bit),
        .carry_in  (carry_q),
        .new_bit   (alu_bit),
        .new_carry (alu_carry),
        .wr_en     (alu_wr),
        .jump      (alu_jump)
    );

    bitproc_byte_merge #(.DATA_W(DATA_W)) u_merge (
        .byte_in  (byte_q),
        .pos      (bit_pos),
        .new_bit  (alu_bit),
        .byte_out (merged)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (op_valid) begin
                state_d = is_carry_only(bp_op_e'(op_code)) ? ST_DONE : ST_READ;
            end
            ST_READ: state_d = ST_EXEC;
            ST_EXEC: state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= BOP_NOP;
            addr_q  <= '0;
            byte_q  <= '0;
            carry_q <= 1'b0;
            jump_q  <= 1'b0;
        end else begin
            if (accept) begin
                op_q   <= bp_op_e'(op_code);
                addr_q <= bit_addr;
                jump_q <= 1'b0;
                if (is_carry_only(bp_op_e'(op_code))) carry_q <= alu_carry;
            end
            if (state_q == ST_READ) byte_q <= mem_rdata;
            if (state_q == ST_EXEC) begin
                carry_q <= alu_carry;
                jump_q  <= alu_jump;
            end
        end
    end

    // Outputs
    always_comb begin
        busy       = (state_q != ST_IDLE);
        done       = (state_q == ST_DONE);
        jump_taken = (state_q == ST_DONE) && jump_q;
        carry      = carry_q;
        mem_rd     = (state_q == ST_READ);
        mem_wr     = (state_q == ST_EXEC) && alu_wr;
        mem_addr   = byte_addr;
        mem_wdata  = merged;
    end

    // A write always follows the read of the same byte.
    a_r10_wr_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $past(mem_rd));
    a_r10_same_byte: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_addr == $past(mem_addr)));
    a_r10_carry_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (carry_q != $past(carry_q)) |-> (state_q == ST_DONE));
    // Only the target lane of the byte may change.
    a_r4_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> ($countones(mem_wdata ^ byte_q) <= 1));
    // Test-and-clear writes only when the bit was set.
    a_r8_no_write_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXEC && op_q == BOP_JSETCLR && !cur_bit) |-> !mem_wr);
    a_r8_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && op_q == BOP_JSETCLR) |-> ((mem_wdata ^ byte_q) != '0));
    a_r9_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && is_carry_only(bp_op_e'(op_code))) |=> (!mem_rd && !mem_wr));
    a_r11_single_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/bitproc_unit_tb.sv
module bitproc_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [3:0] op_code = 4'd15;
    logic [7:0] bit_addr = 8'h00;
    logic       busy, done, jump_taken, carry, mem_rd, mem_wr;
    logic [7:0] mem_addr, mem_wdata, mem_rdata;

    always #4 clk = ~clk;

    bitproc_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .bit_addr(bit_addr), .busy(busy), .done(done), .jump_taken(jump_taken),
        .carry(carry), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Byte storage model with a preload port
    logic [7:0] mem [256];
    logic       ld_en = 1'b0;
    logic [7:0] ld_addr = 8'h00, ld_data = 8'h00;
    int         rd_cnt, wr_cnt;
    logic       clr_mem = 1'b1;

    always_ff @(posedge clk) begin
        if (clr_mem) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
        end else if (ld_en) begin
            mem[ld_addr] <= ld_data;
        end else if (mem_wr) begin
            mem[mem_addr] <= mem_wdata;
        end
    end
    assign mem_rdata = mem[mem_addr];

    always_ff @(posedge clk) begin
        if (clr_mem) begin
            rd_cnt <= 0;
            wr_cnt <= 0;
        end else begin
            rd_cnt <= rd_cnt + (mem_rd ? 1 : 0);
            wr_cnt <= wr_cnt + (mem_wr ? 1 : 0);
        end
    end

    int n_chk = 0, n_fail = 0, cyc = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 50000 cycles", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    task automatic preload(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // Issues one request and returns the latency in cycles to done.
    task automatic run_op(input logic [3:0] op, input logic [7:0] ba, output int lat);
        @(negedge clk);
        op_valid = 1'b1; op_code = op; bit_addr = ba;
        @(negedge clk);
        op_valid = 1'b0;
        lat = 1;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
    endtask

    function automatic string req_of(input logic [3:0] op);
        if (op <= 4'd2) return "R4";
        if (op <= 4'd4) return "R7";
        if (op == 4'd5) return "R8";
        if (op <= 4'd7) return "R5";
        if (op <= 4'd11) return "R6";
        return "R9";
    endfunction

    typedef struct packed {
        logic [3:0] op;
        logic [7:0] baddr;
        logic [7:0] chk_addr;
        logic [7:0] chk_byte;
        logic       exp_c;
        logic       exp_j;
        logic       exp_w;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t [0:NV-1] VECS = '{
        '{4'd0,  8'h00, 8'h20, 8'h01, 1'b0, 1'b0, 1'b1},
        '{4'd0,  8'h0F, 8'h21, 8'h80, 1'b0, 1'b0, 1'b1},
        '{4'd2,  8'h28, 8'h25, 8'hA4, 1'b0, 1'b0, 1'b1},
        '{4'd6,  8'h2A, 8'h25, 8'hA4, 1'b1, 1'b0, 1'b0},
        '{4'd9,  8'h29, 8'h25, 8'hA4, 1'b1, 1'b0, 1'b0},
        '{4'd8,  8'h29, 8'h25, 8'hA4, 1'b0, 1'b0, 1'b0},
        '{4'd11, 8'h2B, 8'h25, 8'hA4, 1'b1, 1'b0, 1'b0},
        '{4'd7,  8'hD7, 8'hD0, 8'h80, 1'b1, 1'b0, 1'b1},
        '{4'd13, 8'h00, 8'hD0, 8'h80, 1'b0, 1'b0, 1'b0},
        '{4'd10, 8'h84, 8'h80, 8'h3C, 1'b1, 1'b0, 1'b0},
        '{4'd3,  8'h85, 8'h80, 8'h3C, 1'b1, 1'b1, 1'b0},
        '{4'd4,  8'h85, 8'h80, 8'h3C, 1'b1, 1'b0, 1'b0},
        '{4'd4,  8'h81, 8'h80, 8'h3C, 1'b1, 1'b1, 1'b0},
        '{4'd5,  8'h83, 8'h80, 8'h34, 1'b1, 1'b1, 1'b1},
        '{4'd5,  8'h83, 8'h80, 8'h34, 1'b1, 1'b0, 1'b0},
        '{4'd14, 8'h00, 8'h80, 8'h34, 1'b0, 1'b0, 1'b0},
        '{4'd12, 8'h00, 8'h80, 8'h34, 1'b1, 1'b0, 1'b0},
        '{4'd1,  8'h2D, 8'h25, 8'h84, 1'b1, 1'b0, 1'b1},
        '{4'd7,  8'h2E, 8'h25, 8'hC4, 1'b1, 1'b0, 1'b1},
        '{4'd15, 8'h00, 8'h80, 8'h34, 1'b1, 1'b0, 1'b0}
    };

    initial begin
        int lat, r0, w0;
        repeat (3) @(negedge clk);
        clr_mem = 1'b0;
        // R1: reset state
        chk("R1", "carry", carry, 0);
        chk("R1", "done", done, 0);
        chk("R1", "jump_taken", jump_taken, 0);
        chk("R1", "busy", busy, 0);
        chk("R1", "mem_rd|mem_wr", mem_rd | mem_wr, 0);
        rst_n = 1'b1;

        preload(8'h25, 8'hA5);
        preload(8'h80, 8'h3C);

        for (int v = 0; v < NV; v++) begin
            r0 = rd_cnt; w0 = wr_cnt;
            run_op(VECS[v].op, VECS[v].baddr, lat);
            chk(req_of(VECS[v].op), "done seen", done, 1);
            chk(req_of(VECS[v].op), "carry", carry, VECS[v].exp_c);
            chk(req_of(VECS[v].op), "jump_taken", jump_taken, VECS[v].exp_j);
            chk(req_of(VECS[v].op), "writes", wr_cnt - w0, VECS[v].exp_w);
            chk(VECS[v].chk_addr < 8'h80 ? "R2/R4" : "R3/R4", "byte",
                mem[VECS[v].chk_addr], VECS[v].chk_byte);
            if (VECS[v].op >= 4'd12) begin
                chk("R9", "reads", rd_cnt - r0, 0);
                chk("R9", "latency", lat, 1);
            end else begin
                chk("R10", "reads", rd_cnt - r0, 1);
                chk("R10", "latency", lat, 3);
            end
            @(negedge clk);
            chk("R11", "done pulse width", done, 0);
            chk("R11", "jump after done", jump_taken, 0);
        end

        // R2 / R3 boundaries
        run_op(4'd0, 8'h7F, lat);
        chk("R2", "byte 0x2F", mem[8'h2F], 8'h80);
        chk("R2", "neighbour 0x2E", mem[8'h2E], 8'h00);
        run_op(4'd0, 8'hFF, lat);
        chk("R3", "byte 0xF8", mem[8'hF8], 8'h80);
        chk("R3", "neighbour 0xF0", mem[8'hF0], 8'h00);
        run_op(4'd0, 8'h80, lat);
        chk("R3", "byte 0x80", mem[8'h80], 8'h35);

        // R12: carry request while busy is ignored
        run_op(4'd13, 8'h00, lat);
        @(negedge clk);
        op_valid = 1'b1; op_code = 4'd3; bit_addr = 8'h85;
        @(negedge clk);
        chk("R12", "busy", busy, 1);
        op_code = 4'd12;
        @(negedge clk);
        @(negedge clk);
        op_valid = 1'b0;
        chk("R12", "done", done, 1);
        chk("R12", "carry", carry, 0);
        chk("R12", "jump_taken", jump_taken, 1);
        @(negedge clk);
        chk("R12", "carry after", carry, 0);

        // R1: reset in the middle of an operation
        run_op(4'd12, 8'h00, lat);
        @(negedge clk);
        op_valid = 1'b1; op_code = 4'd0; bit_addr = 8'h10;
        @(negedge clk);
        op_valid = 1'b0;
        rst_n = 1'b0;
        #1;
        chk("R1", "carry mid reset", carry, 0);
        chk("R1", "mem_wr mid reset", mem_wr, 0);
        chk("R1", "busy mid reset", busy, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "byte untouched", mem[8'h22], 8'h00);
        chk("R1", "done after reset", done, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule